// File: doc/BRIEF.md
# Column Command Latency Scheduler

This block sits on the controller side of a double-data-rate memory interface. It follows read and write column commands once a row has been opened in a bank. Each command carries a bank number and a column address. It may be posted early and is held for a programmable additive latency before it takes effect inside the device. From the additive latency and the CAS latency the block works out when read data appears on the data bus and when write data has to be driven. It raises a read-window or write-window enable for each data-bus cycle a burst occupies. A burst moves two beats per clock, so it occupies half its burst length in cycles.

Accepted commands travel down a shift pipeline. The pipeline is deep enough for the longest read latency plus the longest burst, so several overlapping commands are tracked at once. The block also checks two timing rules. The first is the minimum distance between column commands for the selected burst length. The second is that a command may arrive before the RAS-to-CAS minimum only when the additive latency is non-zero. A command that breaks either rule is dropped and flagged one cycle later.

Top module: `colcmd_sched`

## Requirements
- R1: A read command presented in cycle c makes `rd_window` high starting in cycle c + AL + CL, with AL = `cfg_al` (0..4) and CL = `cfg_cl` (3..5).
- R2: A write command presented in cycle c makes `wr_window` high starting in cycle c + AL + CL − 1.
- R3: A window stays high for 2 cycles when `cfg_bl8` = 0 (4-beat bursts) and for 4 cycles when `cfg_bl8` = 1 (8-beat bursts).
- R4: An accepted command produces a one-cycle `issue_pulse` in cycle c + AL + 1. In that cycle `issue_bank` and `issue_write` match the command, and `issue_col` keeps command bits 11 and 9..0 while bit 10 is forced to 0.
- R5: With `cfg_bl8` = 0, a command arriving less than 2 cycles after the previous accepted command is dropped: it makes no issue pulse and no window. `spacing_err` is then high for one cycle, in the cycle after that command.
- R6: With `cfg_bl8` = 1, the minimum spacing is 4 cycles. A command 2 cycles after the previous one is dropped and flagged. Commands exactly 4 cycles apart are both accepted and give one unbroken 8-cycle window.
- R7: Two reads with 4-beat bursts, 2 cycles apart, give one unbroken 4-cycle read window.
- R8: An activate to bank b in cycle a starts a count for that bank. If `cfg_al` = 0, a command to bank b in a cycle earlier than a + TRCD_MIN (default 4) is dropped, and `early_err` is high in the next cycle. If `cfg_al` > 0, such a command is accepted. A bank that has not been activated since reset counts as ready.
- R9: While reset is held and just after it, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_al | input | 3 | Additive latency, 0..4 |
| cfg_cl | input | 3 | CAS latency, 3..5 |
| cfg_bl8 | input | 1 | 1 = 8-beat bursts, 0 = 4-beat bursts |
| act_valid | input | 1 | Bank activate strobe |
| act_bank | input | 2 | Bank being activated |
| cmd_valid | input | 1 | Column command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_bank | input | 2 | Bank of the column command |
| cmd_col | input | 12 | Column address; bit 10 ignored |
| issue_pulse | output | 1 | Command takes effect internally |
| issue_write | output | 1 | Direction of the issued command |
| issue_bank | output | 2 | Bank of the issued command |
| issue_col | output | 12 | Burst start column, bit 10 zero |
| rd_window | output | 1 | Read data on the bus this cycle |
| wr_window | output | 1 | Write data expected this cycle |
| spacing_err | output | 1 | A command was dropped for spacing |
| early_err | output | 1 | A command was dropped as too early |

## Verification
The vector table runs single reads and writes over several pairs of additive and CAS latency, with both burst lengths. This separates a latency built from the wrong sum from an off-by-one between reads and writes, and a window length taken from the wrong burst setting. The directed cases place command pairs at distances of 1, 2 and 4 cycles in both burst modes. These show whether the pipeline keeps overlapping commands and whether a dropped command still leaks into the windows. Activate-then-command cases with and without additive latency, and on a bank that was never opened, show whether the early-command rule reads the right bank and the right latency setting.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
    localparam int COL_BITS  = 12;
    localparam int BANK_BITS = 2;
    localparam int LAT_BITS  = 3;
    localparam int NO_AP_BIT = 10;

    typedef struct packed {
        logic                 vld;
        logic                 wr;
        logic                 bl8;
        logic [BANK_BITS-1:0] bank;
        logic [COL_BITS-1:0]  col;
    } colcmd_t;
endpackage

// File: rtl/ccs_rcd_track.sv
module ccs_rcd_track
    import ccs_pkg::*;
#(
    parameter int BANKS    = 4,
    parameter int TRCD_MIN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 act_valid_i,
    input  logic [BANK_BITS-1:0] act_bank_i,
    input  logic                 cmd_valid_i,
    input  logic [BANK_BITS-1:0] cmd_bank_i,
    input  logic                 al_zero_i,
    output logic                 early_o,
    output logic                 err_o
);
    localparam int CW = $clog2(TRCD_MIN + 1);

    typedef struct packed {
        logic [BANKS-1:0][CW-1:0] cnt;
        logic                     err;
    } rcd_state_t;

    rcd_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        early_o = cmd_valid_i && al_zero_i &&
                  (int'(st_q.cnt[cmd_bank_i]) < TRCD_MIN);
        st_d.err = early_o;
        for (int b = 0; b < BANKS; b++) begin
            if (act_valid_i && (int'(act_bank_i) == b))
                st_d.cnt[b] = CW'(1);
            else if (int'(st_q.cnt[b]) < TRCD_MIN)
                st_d.cnt[b] = st_q.cnt[b] + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.err <= 1'b0;
            for (int b = 0; b < BANKS; b++)
                st_q.cnt[b] <= CW'(TRCD_MIN);
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o = st_q.err;

    // R8: a command too soon after activate with no additive latency is flagged
    a_r8_early_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && al_zero_i && (int'(st_q.cnt[cmd_bank_i]) < TRCD_MIN)) |=> err_o);
    // R8: with additive latency the early flag never follows
    a_r8_posted_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && !al_zero_i) |=> !err_o);
endmodule

// File: rtl/ccs_spacing.sv
module ccs_spacing #(
    parameter int LONG_GAP  = 4,
    parameter int SHORT_GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid_i,
    input  logic bl8_i,
    input  logic block_i,
    output logic fire_o,
    output logic err_o
);
    localparam int GW = $clog2(LONG_GAP + 1);

    typedef struct packed {
        logic          seen;
        logic [GW-1:0] gap;
        logic          err;
    } sp_state_t;

    sp_state_t st_d, st_q;
    logic      viol;
    int        need;

    always_comb begin
        st_d   = st_q;
        need   = bl8_i ? LONG_GAP : SHORT_GAP;
        viol   = cmd_valid_i && st_q.seen && (int'(st_q.gap) < need);
        fire_o = cmd_valid_i && !viol && !block_i;
        st_d.err = viol;
        if (fire_o) begin
            st_d.seen = 1'b1;
            st_d.gap  = GW'(1);
        end else if (int'(st_q.gap) < LONG_GAP) begin
            st_d.gap = st_q.gap + GW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = st_q.err;

    // R5: two accepted commands never sit in adjacent cycles
    a_r5_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
    // R5: a spacing flag always traces back to a presented command
    a_r5_err_has_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(cmd_valid_i));
endmodule

// File: rtl/ccs_pipe.sv
module ccs_pipe
    import ccs_pkg::*;
#(
    parameter int DEPTH = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  colcmd_t             push_i,
    input  logic [LAT_BITS-1:0] al_i,
    input  logic [LAT_BITS-1:0] cl_i,
    output colcmd_t             issue_o,
    output logic                rd_win_o,
    output logic                wr_win_o
);
    typedef struct packed {
        colcmd_t [DEPTH-1:0] stage;
    } pipe_state_t;

    pipe_state_t st_d, st_q;
    int rl, age, first, span;

    always_comb begin
        st_d.stage[0] = push_i;
        for (int k = 1; k < DEPTH; k++)
            st_d.stage[k] = st_q.stage[k-1];

        issue_o  = (int'(al_i) < DEPTH) ? st_q.stage[al_i] : '0;
        rl       = int'(al_i) + int'(cl_i);
        rd_win_o = 1'b0;
        wr_win_o = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            age   = k + 1;
            first = st_q.stage[k].wr ? rl - 1 : rl;
            span  = st_q.stage[k].bl8 ? 4 : 2;
            if (st_q.stage[k].vld && age >= first && age < first + span) begin
                if (st_q.stage[k].wr) wr_win_o = 1'b1;
                else                  rd_win_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/colcmd_sched.sv
module colcmd_sched
    import ccs_pkg::*;
#(
    parameter int TRCD_MIN = 4,
    parameter int MAX_AL   = 4,
    parameter int MAX_CL   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LAT_BITS-1:0]  cfg_al,
    input  logic [LAT_BITS-1:0]  cfg_cl,
    input  logic                 cfg_bl8,
    input  logic                 act_valid,
    input  logic [BANK_BITS-1:0] act_bank,
    input  logic                 cmd_valid,
    input  logic                 cmd_write,
    input  logic [BANK_BITS-1:0] cmd_bank,
    input  logic [COL_BITS-1:0]  cmd_col,
    output logic                 issue_pulse,
    output logic                 issue_write,
    output logic [BANK_BITS-1:0] issue_bank,
    output logic [COL_BITS-1:0]  issue_col,
    output logic                 rd_window,
    output logic                 wr_window,
    output logic                 spacing_err,
    output logic                 early_err
);
    localparam int BANKS = 1 << BANK_BITS;
    localparam int DEPTH = MAX_AL + MAX_CL + 3;

    logic    early, fire;
    colcmd_t push, issued;

    ccs_rcd_track #(.BANKS(BANKS), .TRCD_MIN(TRCD_MIN)) u_rcd (
        .clk(clk), .rst_n(rst_n),
        .act_valid_i(act_valid), .act_bank_i(act_bank),
        .cmd_valid_i(cmd_valid), .cmd_bank_i(cmd_bank),
        .al_zero_i(cfg_al == '0),
        .early_o(early), .err_o(early_err)
    );

    ccs_spacing #(.LONG_GAP(4), .SHORT_GAP(2)) u_space (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid_i(cmd_valid), .bl8_i(cfg_bl8), .block_i(early),
        .fire_o(fire), .err_o(spacing_err)
    );

    always_comb begin
        push = '0;
        if (fire) begin
            push.vld  = 1'b1;
            push.wr   = cmd_write;
            push.bl8  = cfg_bl8;
            push.bank = cmd_bank;
            push.col  = cmd_col;
            push.col[NO_AP_BIT] = 1'b0;
        end
    end

    ccs_pipe #(.DEPTH(DEPTH)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .push_i(push), .al_i(cfg_al), .cl_i(cfg_cl),
        .issue_o(issued), .rd_win_o(rd_window), .wr_win_o(wr_window)
    );

    assign issue_pulse = issued.vld;
    assign issue_write = issued.vld & issued.wr;
    assign issue_bank  = issued.vld ? issued.bank : '0;
    assign issue_col   = issued.vld ? issued.col : '0;

    // R5: a dropped command never reaches the internal issue point
    a_r5_reject_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !fire && cfg_al == '0) |=> !issue_pulse);
    // R4: the issued column never carries bit 10
    a_r4_col_bit10: assert property (@(posedge clk) disable iff (!rst_n)
        issue_pulse |-> !issue_col[NO_AP_BIT]);
endmodule

// File: tb/colcmd_sched_test.sv
module colcmd_sched_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  cfg_al, cfg_cl;
    logic        cfg_bl8, act_valid, cmd_valid, cmd_write;
    logic [1:0]  act_bank, cmd_bank;
    logic [11:0] cmd_col;
    logic        issue_pulse, issue_write, rd_window, wr_window, spacing_err, early_err;
    logic [1:0]  issue_bank;
    logic [11:0] issue_col;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    colcmd_sched uut (.*);

    typedef struct packed {
        logic [2:0] al;
        logic [2:0] cl;
        logic       bl8;
        logic       wr;
        int         start;
        int         len;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{3'd2, 3'd3, 1'b0, 1'b0, 5, 2},
        '{3'd2, 3'd3, 1'b0, 1'b1, 4, 2},
        '{3'd0, 3'd3, 1'b1, 1'b0, 3, 4},
        '{3'd0, 3'd3, 1'b0, 1'b1, 2, 2},
        '{3'd4, 3'd5, 1'b1, 1'b0, 9, 4},
        '{3'd4, 3'd5, 1'b1, 1'b1, 8, 4},
        '{3'd1, 3'd4, 1'b0, 1'b0, 5, 2},
        '{3'd3, 3'd5, 1'b0, 1'b1, 7, 2}
    };

    int w_first, w_last, w_cnt, i_cnt, i_first, s_cnt, s_first, e_cnt, e_first;
    logic [11:0] i_col;
    logic [1:0]  i_bank;
    logic        i_wr;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample(input int j);
        if (rd_window || wr_window) begin
            if (w_first < 0) w_first = j;
            w_last = j;
            w_cnt++;
        end
        if (issue_pulse) begin
            if (i_first < 0) begin
                i_first = j; i_col = issue_col; i_bank = issue_bank; i_wr = issue_write;
            end
            i_cnt++;
        end
        if (spacing_err) begin if (s_first < 0) s_first = j; s_cnt++; end
        if (early_err)   begin if (e_first < 0) e_first = j; e_cnt++; end
    endtask

    task automatic run_seq(input int t_act, input int t1, input int t2, input logic wr,
                           input logic [1:0] bank, input logic [11:0] col);
        w_first = -1; w_last = -1; w_cnt = 0; i_cnt = 0; i_first = -1;
        s_cnt = 0; s_first = -1; e_cnt = 0; e_first = -1;
        @(negedge clk);
        for (int j = 0; j < 24; j++) begin
            if (j > 0) sample(j);
            act_valid = (j == t_act);
            act_bank  = bank;
            cmd_valid = (j == t1) || (j == t2);
            cmd_write = wr;
            cmd_bank  = bank;
            cmd_col   = col;
            @(negedge clk);
        end
        act_valid = 1'b0;
        cmd_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_al = 3'd0; cfg_cl = 3'd3; cfg_bl8 = 1'b0;
        act_valid = 1'b0; act_bank = 2'd0; cmd_valid = 1'b0; cmd_write = 1'b0;
        cmd_bank = 2'd0; cmd_col = 12'd0;
        repeat (3) @(negedge clk);
        check({issue_pulse, rd_window, wr_window, spacing_err, early_err} == 5'b0,
              "R9 outputs in reset", int'({issue_pulse, rd_window, wr_window, spacing_err, early_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({issue_pulse, rd_window, wr_window, spacing_err, early_err, issue_col} == '0,
              "R9 outputs after reset", int'(issue_col), 0);

        // vector table: R1 R2 R3 R4
        for (int v = 0; v < 8; v++) begin
            cfg_al = VEC[v].al; cfg_cl = VEC[v].cl; cfg_bl8 = VEC[v].bl8;
            run_seq(-1, 0, -1, VEC[v].wr, 2'd0, 12'h012);
            check(w_first == VEC[v].start, VEC[v].wr ? "R2 write window start" : "R1 read window start",
                  w_first, VEC[v].start);
            check(w_cnt == VEC[v].len && w_last == w_first + w_cnt - 1, "R3 window length",
                  w_cnt, VEC[v].len);
            check(i_first == int'(VEC[v].al) + 1 && i_cnt == 1, "R4 issue cycle",
                  i_first, int'(VEC[v].al) + 1);
        end

        // R7: back-to-back 4-beat reads
        cfg_al = 3'd0; cfg_cl = 3'd3; cfg_bl8 = 1'b0;
        run_seq(-1, 0, 2, 1'b0, 2'd0, 12'h0);
        check(w_first == 3 && w_last == 6 && w_cnt == 4, "R7 gapless read window", w_cnt, 4);
        check(i_cnt == 2 && s_cnt == 0, "R7 both accepted", i_cnt, 2);

        // R5: 4-beat commands 1 cycle apart
        run_seq(-1, 0, 1, 1'b0, 2'd0, 12'h0);
        check(s_cnt == 1 && s_first == 2, "R5 spacing flag", s_first, 2);
        check(w_cnt == 2 && i_cnt == 1, "R5 dropped command leaves no window", w_cnt, 2);

        // R6: 8-beat spacing
        cfg_bl8 = 1'b1;
        run_seq(-1, 0, 2, 1'b0, 2'd0, 12'h0);
        check(s_cnt == 1 && s_first == 3, "R6 spacing flag at gap 2", s_first, 3);
        check(w_cnt == 4 && i_cnt == 1, "R6 dropped command leaves no window", w_cnt, 4);
        run_seq(-1, 0, 4, 1'b0, 2'd0, 12'h0);
        check(s_cnt == 0 && i_cnt == 2, "R6 gap 4 accepted", s_cnt, 0);
        check(w_first == 3 && w_last == 10 && w_cnt == 8, "R6 unbroken 8-cycle window", w_cnt, 8);
        cfg_bl8 = 1'b0;

        // R8: early command rule
        run_seq(0, 2, -1, 1'b0, 2'd1, 12'h0);
        check(e_cnt == 1 && e_first == 3, "R8 early flag with AL 0", e_first, 3);
        check(i_cnt == 0 && w_cnt == 0, "R8 early command dropped", i_cnt, 0);
        run_seq(0, 4, -1, 1'b0, 2'd1, 12'h0);
        check(e_cnt == 0 && i_cnt == 1, "R8 command at TRCD_MIN accepted", e_cnt, 0);
        run_seq(-1, 0, -1, 1'b0, 2'd3, 12'h0);
        check(e_cnt == 0 && i_cnt == 1, "R8 unopened bank counts as ready", e_cnt, 0);
        cfg_al = 3'd2;
        run_seq(0, 1, -1, 1'b0, 2'd1, 12'h0);
        check(e_cnt == 0 && i_first == 4, "R8 posted command with AL 2", i_first, 4);
        check(w_first == 6, "R8 posted read window start", w_first, 6);

        // R4: issued fields, column bit 10 dropped
        cfg_al = 3'd0;
        run_seq(-1, 0, -1, 1'b1, 2'd2, 12'hFFF);
        check(i_first == 1 && i_col == 12'hBFF, "R4 issued column", int'(i_col), 'hBFF);
        check(i_bank == 2'd2 && i_wr == 1'b1, "R4 issued bank and write", int'({i_bank, i_wr}), 5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule